// File: doc/BRIEF.md
# Boot-Region Lockout Erase Mapper

This block sits beside the command decoder of a 256K x 16 flash array. Each accepted operation request carries a kind (whole-array erase, sector erase or word program) and an 18-bit word address. One clock later the block answers with a four-bit erase mask, a program-allow bit or a reject flag. The erase mask has one bit per region: bit 0 is the boot region, bit 1 is parameter block 1, bit 2 is parameter block 2 and bit 3 is the main array.

A sticky protect flop guards the boot region at word addresses 0x00000 to 0x01FFF. A single-cycle arm pulse sets the flop, and only power-on reset clears it. While the flop is clear, the boot region is erased as part of the main-array sector. While it is set, that sector erase spares the boot region, a whole-array erase is refused outright, and a word program into the boot region is refused. A high-voltage override input suspends all of this protection for as long as it is held.

During identification reads the block also returns the protect state as data bit 0.

Top module: `bootlock_sector_map`

## Requirements
- R1: After power-on reset the protect flop is clear, `locked` is 0, and `res_valid`, `erase_mask`, `prog_ok` and `reject` are all 0.
- R2: A one-cycle high on `arm_lock` sets `locked` from the next cycle onward. No request and no level of `hv_override` clears it. Only `rst_n` clears it.
- R3: A sector erase (`req_kind`=2'b10) whose address has bits [17:12] equal to 0x03 gives mask 4'b0010. Bits [17:12] equal to 0x05 give mask 4'b0100. Both hold regardless of the protect state.
- R4: A sector erase with address bits [17:12] equal to 0x3F gives mask 4'b1001 while unprotected.
- R5: The same main-array sector erase gives mask 4'b1000 while protected.
- R6: A whole-array erase (`req_kind`=2'b01) gives mask 4'b1111 while unprotected. While protected it gives mask 0 with `reject`=1.
- R7: A word program (`req_kind`=2'b11) gives `prog_ok`=1 and mask 0. The exception is an address in 0x00000 to 0x01FFF while protected: that gives `prog_ok`=0 and `reject`=1.
- R8: While `hv_override` is 1 in the request cycle, all requests are treated as unprotected. Protection applies again on the first request made with `hv_override` at 0.
- R9: `id_bit0` is 1 exactly when `id_mode` is 1, `id_addr` is 0x00002 and the flop is set. This output is combinational.
- R10: A sector erase whose bits [17:12] match none of 0x03, 0x05 or 0x3F, or a request with kind 2'b00, gives mask 0, `prog_ok`=0 and `reject`=1.
- R11: Each request with `req_valid`=1 produces `res_valid`=1 exactly one cycle later. Every result output is 0 in cycles where `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 01 whole erase, 10 sector erase, 11 word program |
| req_addr | input | 18 | Word address of the request |
| arm_lock | input | 1 | Single-cycle pulse that sets the protect flop |
| hv_override | input | 1 | Suspends boot protection while high |
| id_mode | input | 1 | Identification read mode active |
| id_addr | input | 18 | Identification read address |
| res_valid | output | 1 | Result present |
| erase_mask | output | 4 | Regions to erase: {main, param2, param1, boot} |
| prog_ok | output | 1 | Word program permitted |
| reject | output | 1 | Request refused |
| locked | output | 1 | Protect flop state |
| id_bit0 | output | 1 | Protect state as an identification data bit |

## Verification
Request results arrive one clock edge after the request. The protect flop changes one edge after the arm pulse, and `id_bit0` follows its inputs with no register. The driver applies each request on a falling edge and records its expected result in a queue. A monitor on the next falling edge pops that entry whenever `res_valid` is seen, so each comparison lands mid-cycle after exactly one register. No request is issued in the same cycle as an arm pulse, so the protect state in force for every request is unambiguous.

// File: rtl/bootlock_sector_map.sv
module bootlock_sector_map #(
  parameter int AW = 18,
  parameter int BOOT_BITS = 13,
  parameter int TAG_LSB = 12,
  parameter logic [AW-TAG_LSB-1:0] P1_TAG = 'h03,
  parameter logic [AW-TAG_LSB-1:0] P2_TAG = 'h05,
  parameter logic [AW-TAG_LSB-1:0] MAIN_TAG = 'h3F,
  parameter logic [AW-1:0] ID_LOCK_ADDR = 'h00002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          arm_lock,
  input  logic          hv_override,
  input  logic          id_mode,
  input  logic [AW-1:0] id_addr,
  output logic          res_valid,
  output logic [3:0]    erase_mask,
  output logic          prog_ok,
  output logic          reject,
  output logic          locked,
  output logic          id_bit0
);
  localparam int TAG_W = AW - TAG_LSB;
  localparam logic [1:0] K_WHOLE = 2'b01, K_SECT = 2'b10, K_PROG = 2'b11;

  logic lock_q;
  logic [3:0] nxt_mask;
  logic nxt_ok, nxt_rej;

  wire guard = lock_q & ~hv_override;
  wire [TAG_W-1:0] tag = req_addr[AW-1:TAG_LSB];
  wire in_boot = (req_addr[AW-1:BOOT_BITS] == '0);

  always_comb begin
    nxt_mask = '0;
    nxt_ok = 1'b0;
    nxt_rej = 1'b0;
    case (req_kind)
      K_WHOLE: if (guard) nxt_rej = 1'b1; else nxt_mask = 4'b1111;
      K_SECT:
        if (tag == P1_TAG) nxt_mask = 4'b0010;
        else if (tag == P2_TAG) nxt_mask = 4'b0100;
        else if (tag == MAIN_TAG) nxt_mask = guard ? 4'b1000 : 4'b1001;
        else nxt_rej = 1'b1;
      K_PROG: if (in_boot && guard) nxt_rej = 1'b1; else nxt_ok = 1'b1;
      default: nxt_rej = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      res_valid <= 1'b0;
      erase_mask <= '0;
      prog_ok <= 1'b0;
      reject <= 1'b0;
    end else begin
      if (arm_lock) lock_q <= 1'b1;
      res_valid <= req_valid;
      erase_mask <= req_valid ? nxt_mask : 4'b0000;
      prog_ok <= req_valid & nxt_ok;
      reject <= req_valid & nxt_rej;
    end
  end

  assign locked = lock_q;
  assign id_bit0 = id_mode && (id_addr == ID_LOCK_ADDR) && lock_q;

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_lock |=> lock_q);
  p_boot_spared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_q && !hv_override) |=> !erase_mask[0]);
  p_reject_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (erase_mask == 4'b0000) && !prog_ok);
  p_result_due_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (erase_mask == 4'b0000) && !prog_ok && !reject);
  p_prog_no_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> (erase_mask == 4'b0000) && !reject);
endmodule

// File: tb/bootlock_sector_map_tb.sv
module bootlock_sector_map_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, arm_lock = 0, hv_override = 0, id_mode = 0;
  logic [1:0] req_kind = 0;
  logic [17:0] req_addr = 0, id_addr = 0;
  logic res_valid, prog_ok, reject, locked, id_bit0;
  logic [3:0] erase_mask;

  bootlock_sector_map dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .arm_lock(arm_lock),
    .hv_override(hv_override), .id_mode(id_mode), .id_addr(id_addr),
    .res_valid(res_valid), .erase_mask(erase_mask), .prog_ok(prog_ok),
    .reject(reject), .locked(locked), .id_bit0(id_bit0));

  always #5 clk = ~clk;

  typedef struct { logic [3:0] m; logic ok; logic rj; int rq; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  bit model_lock = 0;

  task automatic chk(bit cond, int rq, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic send(logic [1:0] k, logic [17:0] a, bit hv, int rq);
    exp_t e;
    bit g;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; hv_override = hv;
    g = model_lock && !hv;
    e.m = 0; e.ok = 0; e.rj = 0; e.rq = rq;
    if (k == 2'b01) begin if (g) e.rj = 1; else e.m = 4'hF; end
    else if (k == 2'b10) begin
      if (a[17:12] == 6'h03) e.m = 4'b0010;
      else if (a[17:12] == 6'h05) e.m = 4'b0100;
      else if (a[17:12] == 6'h3F) e.m = g ? 4'b1000 : 4'b1001;
      else e.rj = 1;
    end else if (k == 2'b11) begin
      if (a < 18'h02000 && g) e.rj = 1; else e.ok = 1;
    end else e.rj = 1;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; hv_override = 0; arm_lock = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) chk(0, 11, "unexpected result", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(erase_mask == e.m, e.rq, "erase_mask", erase_mask, e.m);
        chk(prog_ok == e.ok, e.rq, "prog_ok", prog_ok, e.ok);
        chk(reject == e.rj, e.rq, "reject", reject, e.rj);
      end
    end
  end

  initial begin
    #2000000;
    chk(0, 11, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23;
    // R1 reset state
    chk(!locked && !res_valid && erase_mask == 0 && !prog_ok && !reject, 1,
        "reset outputs", {locked, res_valid, erase_mask, prog_ok, reject}, 0);
    rst_n = 1;
    send(2'b10, 18'h03123, 0, 3);   // R3 param 1
    send(2'b10, 18'h05FFF, 0, 3);   // R3 param 2
    send(2'b10, 18'h3F000, 0, 4);   // R4 shared sector
    send(2'b01, 18'h05555, 0, 6);   // R6 whole erase open
    send(2'b11, 18'h00010, 0, 7);   // R7 boot program open
    send(2'b10, 18'h10000, 0, 10);  // R10 unmatched
    send(2'b00, 18'h00000, 0, 10);  // R10 idle kind
    idle();
    @(negedge clk);
    // R11 quiet when no result
    chk(!res_valid && erase_mask == 0 && !reject, 11, "quiet", erase_mask, 0);
    id_mode = 1; id_addr = 18'h00002; #1;
    chk(id_bit0 == 0, 9, "id_bit0 unlocked", id_bit0, 0); // R9
    @(negedge clk); arm_lock = 1;
    @(negedge clk); arm_lock = 0; model_lock = 1;
    chk(locked == 1, 2, "locked after arm", locked, 1); // R2
    #1 chk(id_bit0 == 1, 9, "id_bit0 locked", id_bit0, 1); // R9
    id_addr = 18'h00003; #1;
    chk(id_bit0 == 0, 9, "id_bit0 other addr", id_bit0, 0);
    id_addr = 18'h00002; id_mode = 0; #1;
    chk(id_bit0 == 0, 9, "id_bit0 not id mode", id_bit0, 0);
    send(2'b10, 18'h3FABC, 0, 5);   // R5 boot spared
    send(2'b01, 18'h05555, 0, 6);   // R6 whole erase refused
    send(2'b10, 18'h03000, 0, 3);   // R3 param still erasable
    send(2'b11, 18'h01FFF, 0, 7);   // R7 boot top refused
    send(2'b11, 18'h02000, 0, 7);   // R7 just past boot allowed
    send(2'b01, 18'h00000, 1, 8);   // R8 override whole erase
    send(2'b10, 18'h3F000, 1, 8);   // R8 override shared sector
    send(2'b11, 18'h00000, 1, 8);   // R8 override boot program
    send(2'b11, 18'h00000, 0, 8);   // R8 protection back
    send(2'b10, 18'h2F000, 0, 10);  // R10 unmatched locked
    idle();
    @(negedge clk);
    chk(locked == 1, 2, "lock still set", locked, 1); // R2 sticky
    chk(sb.size() == 0, 11, "pending results", sb.size(), 0); // R11
    rst_n = 0; #1;
    chk(locked == 0, 1, "lock cleared by reset", locked, 0); // R1
    #20;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule